// File: doc/BRIEF.md
# Amplifier Readiness Timer

This block tells the rest of the chip when an analog amplifier channel can be trusted after it is switched on or reconfigured. It divides the peripheral clock down to a one-microsecond tick using a programmed timebase value. It then counts two intervals. The first is a fixed warmup interval, set at build time. The second is a settling interval in microseconds, taken from a 7-bit field that software programs.

When both intervals have run out, the `settled` status output goes high. If the channel is in event mode, a single-cycle `ready_evt` pulse is also emitted at that moment.

Any write to the channel's control register restarts the whole sequence. So does a write to its input-selection or resistor-selection register while the channel is enabled, because the output glitches while the switches move. Disabling the channel stops all counting at once.

Top module: `amp_ready_timer`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `settled` and `ready_evt` are both 0.
- R2: One microsecond tick lasts `timebase`+1 clock cycles. Each start or restart resets the divider phase, so the first tick is a full one.
- R3: Call the clock edge that first samples `en` high (after it was low) the start edge. `settled` becomes 1 exactly (WARMUP_US + max(`settle`,1)) × (`timebase`+1) cycles after the start edge.
- R4: A `settle` value of 0 gives the same delay as a value of 1: `settled` rises on the first tick after warmup ends.
- R5: Once `settled` is 1, it stays 1 as long as `en` stays high and no register write strobe arrives.
- R6: When `evt_mode` is 1, `ready_evt` is high for exactly one cycle, in the cycle where `settled` goes from 0 to 1. When `evt_mode` is 0, `ready_evt` stays 0.
- R7: A pulse on `wr_inmux` or `wr_resmux` while `en` is high clears `settled` at the next edge. It then restarts the full delay of R3, counted from that edge.
- R8: A pulse on `wr_ctrl` while `en` is high has the same effect as R7.
- R9: When `en` is low, `settled` and `ready_evt` are 0 from the next edge on. An interrupted count produces no event, and write strobes while `en` is low start nothing.
- R10: The largest `settle` value, 127, gives a delay of (WARMUP_US + 127) × (`timebase`+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel enable |
| evt_mode | input | 1 | 1 selects event mode, which emits a pulse when ready |
| wr_inmux | input | 1 | Write strobe for the input-selection register |
| wr_resmux | input | 1 | Write strobe for the resistor-selection register |
| wr_ctrl | input | 1 | Write strobe for the control register |
| timebase | input | TB_W | Clock cycles per microsecond, minus one |
| settle | input | SET_W | Settling interval in microseconds |
| settled | output | 1 | Ready status flag |
| ready_evt | output | 1 | One-cycle ready event |

## Verification
The assertions check, on every cycle, the relations between the outputs, the strobes and the enable. `settled` may rise only out of the settle phase. The event coincides with that rise, lasts one cycle and requires event mode. A write or a disable clears the flag at the next edge. A settled flag holds while nothing disturbs it.

Only the bench scenarios can show the exact delay. These scenarios measure the cycle count from enable or restart to `settled`, across several timebase and settle values. They include the zero and maximum settle values and restarts caused by each write strobe.

// File: rtl/amp_ready_timer.sv
module amp_ready_timer #(
  parameter int TB_W      = 8,
  parameter int SET_W     = 7,
  parameter int WARMUP_US = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             evt_mode,
  input  logic             wr_inmux,
  input  logic             wr_resmux,
  input  logic             wr_ctrl,
  input  logic [TB_W-1:0]  timebase,
  input  logic [SET_W-1:0] settle,
  output logic             settled,
  output logic             ready_evt
);
  localparam int SMAX = 1 << SET_W;
  localparam int CMAX = (WARMUP_US > SMAX) ? WARMUP_US : SMAX;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WARM, ST_SETTLE, ST_DONE} phase_t;

  phase_t          state;
  logic [TB_W-1:0] pre;
  logic [CW-1:0]   cnt;
  logic            en_q;

  wire any_wr  = wr_inmux | wr_resmux | wr_ctrl;
  wire restart = en & (~en_q | any_wr);
  wire running = (state == ST_WARM) || (state == ST_SETTLE);
  wire tick    = pre >= timebase;
  wire [CW-1:0] cnt_inc = cnt + 1'b1;
  wire warm_end = cnt == CW'(WARMUP_US - 1);
  wire set_end  = cnt_inc >= CW'(settle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pre       <= '0;
      cnt       <= '0;
      en_q      <= 1'b0;
      settled   <= 1'b0;
      ready_evt <= 1'b0;
    end else begin
      en_q      <= en;
      ready_evt <= 1'b0;
      if (!en) begin
        state   <= ST_IDLE;
        pre     <= '0;
        cnt     <= '0;
        settled <= 1'b0;
      end else if (restart) begin
        state   <= ST_WARM;
        pre     <= '0;
        cnt     <= '0;
        settled <= 1'b0;
      end else if (running) begin
        if (!tick) begin
          pre <= pre + 1'b1;
        end else begin
          pre <= '0;
          if (state == ST_WARM) begin
            if (warm_end) begin
              state <= ST_SETTLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt_inc;
            end
          end else if (set_end) begin
            state     <= ST_DONE;
            settled   <= 1'b1;
            ready_evt <= evt_mode;
          end else begin
            cnt <= cnt_inc;
          end
        end
      end
    end
  end

  a_r3_rise_from_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> $past(state == ST_SETTLE));
  a_r5_settled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && en && !any_wr) |=> settled);
  a_r6_evt_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ready_evt |-> ($rose(settled) && $past(evt_mode)));
  a_r6_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    ready_evt |=> !ready_evt);
  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (wr_inmux || wr_resmux)) |=> !settled);
  a_r8_ctrl_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_ctrl) |=> !settled);
  a_r9_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!settled && !ready_evt));
endmodule

// File: tb/amp_ready_timer_bench.sv
module amp_ready_timer_bench;
  localparam int PERIOD = 10;
  localparam int WARM   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, evt_mode = 1'b0;
  logic wr_inmux = 1'b0, wr_resmux = 1'b0, wr_ctrl = 1'b0;
  logic [7:0] timebase = 8'd0;
  logic [6:0] settle = 7'd0;
  logic settled, ready_evt;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  amp_ready_timer #(.TB_W(8), .SET_W(7), .WARMUP_US(WARM)) u_amp_ready_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .evt_mode(evt_mode),
    .wr_inmux(wr_inmux), .wr_resmux(wr_resmux), .wr_ctrl(wr_ctrl),
    .timebase(timebase), .settle(settle),
    .settled(settled), .ready_evt(ready_evt));

  // {timebase[15:8], settle[7:1], evt_mode[0]}
  localparam logic [15:0] VEC [6] = '{
    {8'd0, 7'd5,  1'b1}, {8'd3, 7'd2,  1'b1}, {8'd1, 7'd0, 1'b1},
    {8'd2, 7'd1,  1'b0}, {8'd7, 7'd4,  1'b0}, {8'd0, 7'd127, 1'b1}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lat(input int tb, input int st);
    return (WARM + ((st == 0) ? 1 : st)) * (tb + 1) + 1;
  endfunction

  // start stimulus was applied just before; first negedge counts as 1
  task automatic measure(input int exp_n, input bit exp_evt, input string req);
    int got = 0, evc = 0, evt_at = 0;
    for (int n = 1; n <= exp_n + 12; n++) begin
      @(negedge clk);
      wr_inmux = 1'b0; wr_resmux = 1'b0; wr_ctrl = 1'b0;
      if (ready_evt) begin evc++; if (evt_at == 0) evt_at = n; end
      if (settled && got == 0) got = n;
      if (got != 0 && !settled) got = -1;
    end
    check(got == exp_n, req, got, exp_n);
    check(evc == (exp_evt ? 1 : 0), "R6 event count", evc, exp_evt ? 1 : 0);
    if (exp_evt) check(evt_at == exp_n, "R6 event timing", evt_at, exp_n);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!settled && !ready_evt, "R1 in reset", settled, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!settled && !ready_evt, "R1 after reset", settled, 0);

    foreach (VEC[i]) begin
      en = 1'b0;
      repeat (2) @(negedge clk);
      timebase = VEC[i][15:8]; settle = VEC[i][7:1]; evt_mode = VEC[i][0];
      en = 1'b1;
      measure(lat(VEC[i][15:8], VEC[i][7:1]), VEC[i][0],
              (VEC[i][7:1] == 0) ? "R4 zero settle" :
              (VEC[i][7:1] == 127) ? "R10 max settle" : "R2 R3 latency");
    end

    // R5 and restarts from settled state
    en = 1'b0; @(negedge clk);
    timebase = 8'd2; settle = 7'd3; evt_mode = 1'b1; en = 1'b1;
    measure(lat(2, 3), 1'b1, "R3 latency");
    repeat (20) @(negedge clk);
    check(settled, "R5 holds", settled, 1);
    wr_inmux = 1'b1;
    measure(lat(2, 3), 1'b1, "R7 inmux restart");
    wr_resmux = 1'b1;
    measure(lat(2, 3), 1'b1, "R7 resmux restart");
    wr_ctrl = 1'b1;
    measure(lat(2, 3), 1'b1, "R8 ctrl restart");

    // R2 mid-count restart realigns prescaler phase
    en = 1'b0; @(negedge clk); en = 1'b1;
    repeat (7) @(negedge clk);
    wr_ctrl = 1'b1;
    measure(lat(2, 3), 1'b1, "R2 R8 midcount restart");

    // R9 disable after settled
    en = 1'b0; @(negedge clk);
    check(!settled, "R9 disable clears", settled, 0);
    // R9 disable mid-count: no event, no settle
    en = 1'b1; repeat (10) @(negedge clk);
    en = 1'b0;
    begin
      int seen = 0;
      for (int n = 0; n < 60; n++) begin
        @(negedge clk);
        if (settled || ready_evt) seen++;
      end
      check(seen == 0, "R9 interrupted count", seen, 0);
      wr_ctrl = 1'b1; wr_inmux = 1'b1;
      @(negedge clk); wr_ctrl = 1'b0; wr_inmux = 1'b0;
      for (int n = 0; n < 60; n++) begin
        @(negedge clk);
        if (settled || ready_evt) seen++;
      end
      check(seen == 0, "R9 writes while disabled", seen, 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule